// File: doc/BRIEF.md
# Two-Lane Parallel Adjacent-Sample Summer

This block computes the running sum of each sample and the sample before it. It accepts two consecutive samples in every clock cycle and so runs at half the sample rate. Each accepted cycle delivers one pair of input samples: lane 0 carries the older sample and lane 1 the newer one.

Two adders work in parallel. Lane 1 adds the newer sample to the older sample of the same pair. Lane 0 adds the older sample to a history register. That register holds the newer sample of the last accepted pair.

The number of lanes and the sample width are parameters. The defaults are two lanes of 5-bit samples. Each result is one bit wider than a sample, so no sum can wrap. The results are registered, and they appear one cycle after the pair that produced them.

Top module: `pair_sum_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0, `out_sums` is all zeros and the history register is zero.
- R2: Lane 1 of `out_sums` (bits 11:6) equals the sum of lane 1 (bits 9:5, newer) and lane 0 (bits 4:0, older) of the `in_samples` accepted one cycle earlier.
- R3: Lane 0 of `out_sums` (bits 5:0) equals the older sample of the accepted pair plus the newer sample of the previously accepted pair.
- R4: For the first pair accepted after reset, the lane 0 result equals that pair's older sample alone.
- R5: `out_valid` equals `in_valid` of the previous cycle.
- R6: A cycle with `in_valid` low does not change the history register, so the next accepted pair still pairs with the last accepted newer sample.
- R7: Each result is 6 bits wide and holds the exact sum, including 31 + 31 = 62.
- R8: In a cycle with `in_valid` low, `out_sums` keeps its previous value one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at half the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The sample pair on `in_samples` is accepted this cycle |
| in_samples | input | 10 | Bits 4:0 carry the older sample, bits 9:5 the newer sample |
| out_valid | output | 1 | `out_sums` carries a new result pair |
| out_sums | output | 12 | Bits 5:0 carry the older-lane sum, bits 11:6 the newer-lane sum |

## Verification
The assertions assume that `in_valid` and `in_samples` are driven to known values whenever reset is released. They also assume that each accepted pair is in time order, with the older sample in lane 0.

The stimulus drives its inputs shortly after each rising edge and keeps them at 0 during reset. It mixes bursts of back-to-back valid pairs with random idle gaps. It also includes all-ones samples, so the largest sum is reached.

// File: rtl/pair_sum_pkg.sv
package pair_sum_pkg;
   // Width of a two-operand sum that cannot wrap.
   function automatic int sum_width(input int sample_w);
      return sample_w + 1;
   endfunction
endpackage

// File: rtl/pair_sum_history.sv
module pair_sum_history #(
   parameter int SAMPLE_W = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [SAMPLE_W-1:0] newest,
   output logic [SAMPLE_W-1:0] prev_newest
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    prev_newest <= '0;
      else if (load) prev_newest <= newest;
   end

   // R6: idle cycles leave the history untouched
   a_r6_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(prev_newest));
endmodule

// File: rtl/pair_sum_adder.sv
module pair_sum_adder
   import pair_sum_pkg::*;
#(
   parameter int SAMPLE_W = 5,
   localparam int SUM_W = sum_width(SAMPLE_W)
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [SAMPLE_W-1:0] partner,
   output logic [SUM_W-1:0]    sum
);
   always_comb sum = SUM_W'(sample) + SUM_W'(partner);
endmodule

// File: rtl/pair_sum_filter.sv
module pair_sum_filter
   import pair_sum_pkg::*;
#(
   parameter int SAMPLE_W = 5,
   parameter int LANES    = 2,
   localparam int SUM_W   = sum_width(SAMPLE_W),
   localparam int IN_W    = LANES * SAMPLE_W,
   localparam int OUT_W   = LANES * SUM_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_samples,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_sums
);
   initial begin
      assert (SAMPLE_W >= 1) else $error("SAMPLE_W must be at least 1");
      assert (LANES >= 1)    else $error("LANES must be at least 1");
   end

   logic [SAMPLE_W-1:0] hist;
   logic [OUT_W-1:0]    sums_d;

   pair_sum_history #(.SAMPLE_W(SAMPLE_W)) u_hist (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (in_valid),
      .newest      (in_samples[IN_W-1 -: SAMPLE_W]),
      .prev_newest (hist)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [SAMPLE_W-1:0] partner;
      if (i == 0) begin : g_oldest
         assign partner = hist;
      end else begin : g_inner
         assign partner = in_samples[(i-1)*SAMPLE_W +: SAMPLE_W];
      end

      pair_sum_adder #(.SAMPLE_W(SAMPLE_W)) u_add (
         .sample  (in_samples[i*SAMPLE_W +: SAMPLE_W]),
         .partner (partner),
         .sum     (sums_d[i*SUM_W +: SUM_W])
      );

      if (i > 0) begin : g_chk
         // R2, R7: each inner lane holds the full, unwrapped sum of adjacent inputs
         a_r7_full_sum: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> 32'(out_sums[i*SUM_W +: SUM_W]) ==
               32'($past(in_samples[i*SAMPLE_W +: SAMPLE_W])) +
               32'($past(in_samples[(i-1)*SAMPLE_W +: SAMPLE_W])));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sums  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_sums <= sums_d;
      end
   end

   // R5: one-cycle valid latency
   a_r5_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));
   // R8: results hold across idle cycles
   a_r8_hold_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_sums));
   // R1: reset leaves the output idle
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> !out_valid && out_sums == '0);
endmodule

// File: tb/pair_sum_filter_test.sv
`timescale 1ns/1ps
module pair_sum_filter_test;
   localparam int SW = 5;
   localparam int OW = SW + 1;

   typedef struct {
      logic            v;
      logic [OW-1:0]   e0;
      logic [OW-1:0]   e1;
      string           tag0;
      string           tag1;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            in_valid;
   logic [2*SW-1:0] in_samples;
   logic            out_valid;
   logic [2*OW-1:0] out_sums;

   int total = 0;
   int bad   = 0;
   exp_t q[$];
   logic [SW-1:0] model_hist = '0;
   logic [OW-1:0] last0 = '0, last1 = '0;
   bit first_after_reset = 1'b1;

   always #4 clk = ~clk;

   pair_sum_filter uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_samples(in_samples), .out_valid(out_valid), .out_sums(out_sums)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Driver: applies one cycle of stimulus and queues the serial model's result.
   task automatic drive(input bit v, input logic [SW-1:0] older, input logic [SW-1:0] newer);
      exp_t it;
      @(posedge clk);
      #2;
      in_valid   = v;
      in_samples = {newer, older};
      it.v = v;
      if (v) begin
         it.e0 = OW'(older) + OW'(model_hist);
         it.e1 = OW'(newer) + OW'(older);
         it.tag0 = first_after_reset ? "R4" : "R3/R6";
         it.tag1 = "R2/R7";
         model_hist = newer;
         first_after_reset = 1'b0;
         last0 = it.e0;
         last1 = it.e1;
      end else begin
         it.e0 = last0;
         it.e1 = last1;
         it.tag0 = "R8";
         it.tag1 = "R8";
      end
      q.push_back(it);
   endtask

   // Monitor: compares each registered result with the queued expectation.
   initial begin
      exp_t it;
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            it = q.pop_front();
            check("R5", int'(out_valid), int'(it.v));
            check(it.tag0, int'(out_sums[OW-1:0]), int'(it.e0));
            check(it.tag1, int'(out_sums[2*OW-1:OW]), int'(it.e1));
         end
      end
   end

   initial begin
      #(200000 * 8);
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      in_valid = 1'b0;
      in_samples = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R1", int'(out_valid), 0);
      check("R1", int'(out_sums), 0);
      @(posedge clk);
      #2;
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1", int'(out_valid), 0);

      drive(1, 5'd5, 5'd9);    // R4: first older result equals 5
      drive(1, 5'd3, 5'd7);    // R3: 3 + 9
      drive(0, 5'd30, 5'd30);  // R6, R8: idle pair must not disturb anything
      drive(0, 5'd1, 5'd2);
      drive(1, 5'd4, 5'd0);    // R6: 4 + 7 from before the gap
      drive(1, 5'd31, 5'd31);  // R7: 31 + 0 and 62
      drive(1, 5'd31, 5'd31);  // R7: 62 on both lanes
      drive(1, 5'd0, 5'd0);
      for (int k = 0; k < 400; k++) begin
         drive(($urandom % 4) != 0, 5'($urandom), 5'($urandom));
      end
      drive(0, 5'd0, 5'd0);
      repeat (3) @(posedge clk);
      #3;
      check("R5", q.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule